// File: doc/BRIEF.md
# UART Baud Clock Generator

This block turns the system clock into the 16x oversampling enable that a UART transmitter and receiver use to pace their bit timing. It first picks a source rate. The source can be the system clock itself, the system clock divided by eight, or the system clock divided by an even factor taken from a 4-bit prescale field. As an alternative, an external clock pin can drive the source. That pin is brought into the system clock domain by a synchroniser, and each of its rising edges counts as one source event.

The source events then drive an 8-bit reload counter. The counter emits one `tick_16x` pulse for every m + 1 source events. The resulting bit rate is therefore the source rate divided by 16(m + 1). Every division is done with single-cycle enables in the system clock domain, so the block creates no derived clock. When `enable` is low, all counters return to their start state and the tick output stays low.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, `tick_16x` is low until the first source event of an enabled generator.
- R2: With `ext_sel`=0 and `src_sel`=0 (undivided), ticks are spaced exactly m+1 system cycles apart, where m is `divisor`.
- R3: With `src_sel`=1 (fixed divide-by-8), ticks are spaced 8(m+1) system cycles apart.
- R4: With `src_sel`=2 and `presc_n`=n in 1..15, ticks are spaced 2n(m+1) system cycles apart.
- R5: With `src_sel`=2 and `presc_n`=0, there is no prescaling, so ticks are spaced m+1 cycles apart.
- R6: With `ext_sel`=1, each rising edge of `ext_clk` is one source event, so ticks are spaced P(m+1) cycles apart for a pin period of P cycles, and `src_sel` has no effect.
- R7: A level held high on `ext_clk` counts only once. A single rising edge with m=0 gives exactly one tick.
- R8: Whenever the tick period is longer than one cycle, each tick lasts exactly one system cycle.
- R9: While `enable` is low, no tick is produced. In undivided mode with `enable` raised, the first tick appears on the cycle after `enable` rises.
- R10: A new `divisor` written mid-count leaves the current interval unchanged and takes effect from the next reload.
- R11: The reserved `src_sel` value 3 behaves like the undivided source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator when high; clears all counters when low |
| src_sel | input | 2 | Internal source: 0 undivided, 1 divide-by-8, 2 prescaled, 3 undivided |
| presc_n | input | 4 | Prescale factor n: 0 means no division, otherwise division by 2n |
| divisor | input | 8 | Reload value m; the 16x rate is the source rate divided by m+1 |
| ext_sel | input | 1 | Selects the synchronised external pin as the source |
| ext_clk | input | 1 | External source clock pin, asynchronous |
| tick_16x | output | 1 | Single-cycle enable at 16 times the bit rate |

## Verification
The bench builds the block with its defaults: an 8-bit divisor, a 4-bit prescale field, a fixed divide-by-8 tap and a two-stage synchroniser. These widths are small enough that every prescale value from 0 to 15 can be swept against several divisors. They also allow the full 255 divisor in undivided mode, and each case is judged by comparing the measured tick spacing with the spacing expected from the arithmetic. The external pin is driven with several duty cycles and periods, which shows that only the pin period matters, and it is also held high for a long stretch to show that a single edge counts once.

// File: rtl/baud_pkg.sv
package baud_pkg;
    typedef enum logic [1:0] {
        SRC_UNDIV = 2'd0,
        SRC_DIV8  = 2'd1,
        SRC_PRESC = 2'd2,
        SRC_RSVD  = 2'd3
    } src_sel_e;
endpackage

// File: rtl/baud_ext_sync.sv
module baud_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], pin};
        st_d.prev  = st_q.chain[STAGES-1];
        rise       = st_q.chain[STAGES-1] & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    one_edge_per_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baud_pkg::*;
#(
    parameter int PRE_W     = 4,
    parameter int FIXED_DIV = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  src_sel_e         src_sel,
    input  logic [PRE_W-1:0] presc_n,
    output logic             pulse
);
    localparam int FIX_W  = $clog2(FIXED_DIV);
    localparam int PCNT_W = (FIX_W > PRE_W + 1) ? FIX_W : PRE_W + 1;

    typedef struct packed {
        logic [PCNT_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [PCNT_W-1:0] term;

    always_comb begin
        unique case (src_sel)
            SRC_DIV8:  term = PCNT_W'(FIXED_DIV - 1);
            SRC_PRESC: term = (presc_n == '0) ? '0
                            : PCNT_W'({presc_n, 1'b0}) - PCNT_W'(1);
            default:   term = '0;
        endcase

        pulse = en && (st_q.cnt >= term);

        st_d = st_q;
        if (!en)        st_d.cnt = '0;
        else if (pulse) st_d.cnt = '0;
        else            st_d.cnt = st_q.cnt + PCNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    pre_idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q.cnt == '0));
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             src_en,
    input  logic [DIV_W-1:0] reload,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        hit     = en && src_en && (st_q.cnt == '0);
        st_d    = st_q;
        st_d.tick = hit;
        if (!en)          st_d.cnt = '0;
        else if (hit)     st_d.cnt = reload;
        else if (src_en)  st_d.cnt = st_q.cnt - DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

    // R10
    reload_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && src_en && st_q.cnt == '0) |=> (st_q.cnt == $past(reload)));

    // R8
    tick_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tick && st_q.cnt != '0) |=> !st_q.tick);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int PRE_W       = 4,
    parameter int FIXED_DIV   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       src_sel,
    input  logic [PRE_W-1:0] presc_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic             ext_sel,
    input  logic             ext_clk,
    output logic             tick_16x
);
    logic ext_rise;
    logic pre_pulse;
    logic src_en;

    baud_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_clk),
        .rise  (ext_rise)
    );

    baud_prescaler #(.PRE_W(PRE_W), .FIXED_DIV(FIXED_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (enable && !ext_sel),
        .src_sel (src_sel_e'(src_sel)),
        .presc_n (presc_n),
        .pulse   (pre_pulse)
    );

    assign src_en = ext_sel ? ext_rise : pre_pulse;

    baud_divider #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (enable),
        .src_en (src_en),
        .reload (divisor),
        .tick   (tick_16x)
    );

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !tick_16x);
endmodule

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic [3:0] presc_n = 4'd0;
    logic [7:0] divisor = 8'd0;
    logic       ext_sel = 1'b0;
    logic       ext_clk = 1'b0;
    logic       tick_16x;

    int compared = 0;
    int mismatched = 0;
    bit ext_run = 1'b0;
    int ext_hi = 2;
    int ext_lo = 2;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_tick_gen dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .src_sel(src_sel),
        .presc_n(presc_n), .divisor(divisor), .ext_sel(ext_sel),
        .ext_clk(ext_clk), .tick_16x(tick_16x)
    );

    always begin
        if (ext_run) begin
            repeat (ext_lo) @(negedge clk);
            ext_clk = 1'b1;
            repeat (ext_hi) @(negedge clk);
            ext_clk = 1'b0;
        end else begin
            @(negedge clk);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick_16x && n < LIMIT);
    endtask

    // run a configuration from a fresh enable and check three tick spacings
    task automatic run_case(input string req, input int exp);
        int n;
        enable = 1'b0;
        repeat (3) @(negedge clk);
        enable = 1'b1;
        wait_tick(n);
        for (int k = 0; k < 3; k++) begin
            wait_tick(n);
            check(req, n, exp);
        end
        enable = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int n;
        int ones;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset", int'(tick_16x), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 idle after reset", int'(tick_16x), 0);

        // R9: disabled generator stays quiet
        src_sel = 2'd0; divisor = 8'd0; enable = 1'b0;
        ones = 0;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (tick_16x) ones++;
        end
        check("R9 no tick while disabled", ones, 0);

        // R9: first tick one cycle after enable, undivided, m=5
        divisor = 8'd5;
        enable = 1'b1;
        wait_tick(n);
        check("R9 first tick latency", n, 1);
        wait_tick(n);
        check("R9 spacing after start", n, 6);
        enable = 1'b0;

        // R2: undivided sweep
        for (int m = 0; m < 16; m++) begin
            src_sel = 2'd0; divisor = 8'(m);
            run_case("R2 undivided", m + 1);
        end
        divisor = 8'd255;
        run_case("R2 undivided m=255", 256);

        // R8: tick width with m=1
        src_sel = 2'd0; divisor = 8'd1; enable = 1'b1;
        wait_tick(n);
        @(negedge clk);
        check("R8 tick one cycle wide", int'(tick_16x), 0);
        enable = 1'b0;

        // R11: reserved source code
        src_sel = 2'd3;
        for (int m = 0; m < 4; m++) begin
            divisor = 8'(m * 3);
            run_case("R11 reserved code as undivided", m * 3 + 1);
        end

        // R3: fixed divide-by-8
        src_sel = 2'd1;
        for (int m = 0; m < 5; m++) begin
            divisor = 8'(m);
            run_case("R3 divide-by-8", 8 * (m + 1));
        end

        // R4 / R5: prescale sweep
        src_sel = 2'd2;
        for (int p = 0; p < 16; p++) begin
            for (int mi = 0; mi < 3; mi++) begin
                int mv;
                mv = (mi == 0) ? 0 : ((mi == 1) ? 1 : 5);
                presc_n = 4'(p); divisor = 8'(mv);
                if (p == 0) run_case("R5 prescale n=0", mv + 1);
                else        run_case("R4 prescale 2n", 2 * p * (mv + 1));
            end
        end

        // R10: divisor change mid-count
        src_sel = 2'd0; divisor = 8'd20; enable = 1'b1;
        wait_tick(n);
        wait_tick(n);
        repeat (3) @(negedge clk);
        divisor = 8'd4;
        wait_tick(n);
        check("R10 current interval kept", n + 3, 21);
        wait_tick(n);
        check("R10 new value after reload", n, 5);
        enable = 1'b0;

        // R6: external source, src_sel ignored
        ext_sel = 1'b1;
        for (int cfg = 0; cfg < 4; cfg++) begin
            ext_hi = (cfg == 2) ? 5 : 2;
            ext_lo = (cfg == 3) ? 7 : 2;
            src_sel = 2'(cfg);
            presc_n = 4'd3;
            divisor = 8'(cfg);
            ext_run = 1'b1;
            run_case("R6 external source", (ext_hi + ext_lo) * (cfg + 1));
            ext_run = 1'b0;
            repeat (12) @(negedge clk);
        end

        // R7: a single long high level counts once
        ext_clk = 1'b0; divisor = 8'd0;
        repeat (6) @(negedge clk);
        enable = 1'b1;
        repeat (4) @(negedge clk);
        ext_clk = 1'b1;
        ones = 0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (tick_16x) ones++;
        end
        check("R7 held level counts once", ones, 1);
        enable = 1'b0;
        ext_clk = 1'b0;
        ext_sel = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule